// File: doc/BRIEF.md
# RS-485 Direction-Controlled UART Transmitter

This block is the transmit half of a UART that also steers an external half-duplex RS-485 transceiver. The host pushes bytes into a small transmit queue through a one-cycle write strobe. A shift register turns each byte into a serial frame, one bit per period of an externally supplied baud tick. No software decides when the line driver is turned on or off. Control logic watches the queue and the shift register together and raises the direction output before the first start bit. It keeps that output raised while any data is waiting or moving, and drops it only after a fixed guard interval that follows the last stop bit.

The turn-on lead is one bit period and the turn-off guard is three bit periods, and neither can be changed at run time. The guard gives the stop bit time to pass fully through the transceiver before the bus is released. When more data arrives while the guard is still running, the guard is abandoned and the next frame starts on the next bit boundary, so the line is never handed back to the receiver between frames.

Top module: `rs485_uart_tx`

## Requirements
- R1: While reset is held and just after it is released, `txd` is 1, `dir_tx` is 0 (receive) and `full` is 0.
- R2: Every frame is one start bit at 0, then the eight data bits with bit 0 first, then one stop bit at 1. Each bit lasts exactly one `baud_tick` period.
- R3: When data waits and the line is in receive, `dir_tx` rises in the cycle after a baud tick while `txd` stays 1. The start bit begins one baud tick later, which gives exactly one bit period of lead.
- R4: `dir_tx` is 1 whenever a frame is being shifted out, so `txd` is never 0 while `dir_tx` is 0.
- R5: Once the last stop bit has ended and the queue is empty, `dir_tx` stays 1 for exactly three more baud-tick periods and then falls to 0, with `txd` at 1.
- R6: If a byte is written while the guard interval runs, the guard is cancelled. The new start bit begins at the next baud tick and `dir_tx` never falls.
- R7: If the queue holds another byte when a stop bit ends, that byte's start bit follows immediately with no idle bit between the frames.
- R8: The queue holds 16 bytes and sends them in write order. `full` is 1 when it holds 16, and a write while `full` is 1 is dropped.
- R9: `txd` and `dir_tx` change only in the cycle after one in which `baud_tick` was 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for one byte |
| wr_data | input | 8 | Byte to queue |
| full | output | 1 | Queue holds 16 bytes, so writes are dropped |
| baud_tick | input | 1 | One-cycle pulse marking each bit boundary |
| txd | output | 1 | Serial transmit line, idles at 1 |
| dir_tx | output | 1 | Transceiver direction: 1 drive, 0 receive |

## Verification
The assertions check on every cycle that the outputs move only after a baud tick, that the line is never driven low while the transceiver is set to receive, and that direction rises with the line still idle and falls only with the line high. The exact lengths of the lead and guard intervals, the bit order inside a frame, the absence of gaps between queued frames, guard cancellation and the dropping of writes when the queue is full all depend on a sequence of ticks and writes. Only the bench's scenarios can show these, by walking the tick boundaries one at a time.

// File: rtl/rs485_tx_pkg.sv
package rs485_tx_pkg;

    localparam int DATA_W     = 8;
    localparam int FIFO_DEPTH = 16;
    localparam int GUARD_BITS = 3;

    typedef enum logic [1:0] {
        DIR_IDLE,
        DIR_LEAD,
        DIR_SEND,
        DIR_GUARD
    } dir_state_e;

    typedef struct packed {
        logic empty;
        logic full;
    } fifo_flags_t;

endpackage

// File: rtl/rs485_tx_fifo.sv
module rs485_tx_fifo
    import rs485_tx_pkg::*;
#(
    parameter int DW    = DATA_W,
    parameter int DEPTH = FIFO_DEPTH
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              push,
    input  logic [DW-1:0]     push_data,
    input  logic              pop,
    output logic [DW-1:0]     head,
    output fifo_flags_t       flags
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = AW + 1;

    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] wptr, rptr;
    logic [CW-1:0] count;
    logic          do_push, do_pop;

    assign do_push     = push && !flags.full;
    assign do_pop      = pop && !flags.empty;
    assign head        = mem[rptr];
    assign flags.empty = (count == '0);
    assign flags.full  = (count == CW'(DEPTH));

    always_ff @(posedge clk) begin
        if (do_push) mem[wptr] <= push_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (do_push) wptr <= (wptr == AW'(DEPTH - 1)) ? '0 : wptr + 1'b1;
            if (do_pop)  rptr <= (rptr == AW'(DEPTH - 1)) ? '0 : rptr + 1'b1;
            if (do_push && !do_pop)      count <= count + 1'b1;
            else if (do_pop && !do_push) count <= count - 1'b1;
        end
    end
endmodule

// File: rtl/rs485_tx_shifter.sv
module rs485_tx_shifter
    import rs485_tx_pkg::*;
#(
    parameter int DW = DATA_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick,
    input  logic          load,
    input  logic [DW-1:0] load_data,
    output logic          txd,
    output logic          stop_end
);
    localparam int FB = DW + 2;
    localparam int CW = $clog2(FB);

    logic [FB-1:0] sreg;
    logic [CW-1:0] bitcnt;
    logic          busy;

    assign txd      = sreg[0];
    assign stop_end = tick && busy && (bitcnt == CW'(FB - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            sreg   <= '1;
            bitcnt <= '0;
            busy   <= 1'b0;
        end else if (load) begin
            sreg   <= {1'b1, load_data, 1'b0};
            bitcnt <= '0;
            busy   <= 1'b1;
        end else if (tick && busy) begin
            sreg <= {1'b1, sreg[FB-1:1]};
            if (bitcnt == CW'(FB - 1)) begin
                bitcnt <= '0;
                busy   <= 1'b0;
            end else begin
                bitcnt <= bitcnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/rs485_dir_ctrl.sv
module rs485_dir_ctrl
    import rs485_tx_pkg::*;
#(
    parameter int GUARD = GUARD_BITS
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic fifo_empty,
    input  logic stop_end,
    output logic pop,
    output logic dir_tx
);
    localparam int GW = $clog2(GUARD + 1);

    dir_state_e    state;
    logic [GW-1:0] gcnt;

    always_comb begin
        pop = 1'b0;
        if (tick && !fifo_empty) begin
            unique case (state)
                DIR_LEAD:  pop = 1'b1;
                DIR_SEND:  pop = stop_end;
                DIR_GUARD: pop = 1'b1;
                default:   pop = 1'b0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= DIR_IDLE;
            gcnt   <= '0;
            dir_tx <= 1'b0;
        end else begin
            unique case (state)
                DIR_IDLE: if (tick && !fifo_empty) begin
                    state  <= DIR_LEAD;
                    dir_tx <= 1'b1;
                end
                DIR_LEAD: if (tick) state <= DIR_SEND;
                DIR_SEND: if (stop_end && fifo_empty) begin
                    state <= DIR_GUARD;
                    gcnt  <= '0;
                end
                DIR_GUARD: if (tick) begin
                    if (!fifo_empty) begin
                        state <= DIR_SEND;
                    end else if (gcnt == GW'(GUARD - 1)) begin
                        state  <= DIR_IDLE;
                        dir_tx <= 1'b0;
                    end else begin
                        gcnt <= gcnt + 1'b1;
                    end
                end
                default: state <= DIR_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/rs485_uart_tx.sv
module rs485_uart_tx
    import rs485_tx_pkg::*;
#(
    parameter int DW    = DATA_W,
    parameter int DEPTH = FIFO_DEPTH,
    parameter int GUARD = GUARD_BITS
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    output logic          full,
    input  logic          baud_tick,
    output logic          txd,
    output logic          dir_tx
);
    fifo_flags_t   flags;
    logic [DW-1:0] head;
    logic          pop;
    logic          stop_end;

    assign full = flags.full;

    rs485_tx_fifo #(.DW(DW), .DEPTH(DEPTH)) u_fifo (
        .clk       (clk),
        .rst       (rst),
        .push      (wr_en),
        .push_data (wr_data),
        .pop       (pop),
        .head      (head),
        .flags     (flags)
    );

    rs485_tx_shifter #(.DW(DW)) u_shift (
        .clk       (clk),
        .rst       (rst),
        .tick      (baud_tick),
        .load      (pop),
        .load_data (head),
        .txd       (txd),
        .stop_end  (stop_end)
    );

    rs485_dir_ctrl #(.GUARD(GUARD)) u_dir (
        .clk        (clk),
        .rst        (rst),
        .tick       (baud_tick),
        .fifo_empty (flags.empty),
        .stop_end   (stop_end),
        .pop        (pop),
        .dir_tx     (dir_tx)
    );
endmodule

// File: rtl/rs485_uart_tx_chk.sv
module rs485_uart_tx_chk (
    input logic clk,
    input logic rst,
    input logic baud_tick,
    input logic txd,
    input logic dir_tx
);
    // R4
    line_low_needs_dir_chk: assert property (@(posedge clk) disable iff (rst)
        !txd |-> dir_tx);

    // R9
    dir_on_tick_chk: assert property (@(posedge clk) disable iff (rst)
        !baud_tick |=> $stable(dir_tx));

    // R9
    txd_on_tick_chk: assert property (@(posedge clk) disable iff (rst)
        !baud_tick |=> $stable(txd));

    // R3
    lead_idle_line_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(dir_tx) |-> txd && $past(txd));

    // R5
    release_high_line_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(dir_tx) |-> txd && $past(txd));
endmodule

bind rs485_uart_tx rs485_uart_tx_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .baud_tick (baud_tick),
    .txd       (txd),
    .dir_tx    (dir_tx)
);

// File: tb/rs485_uart_tx_tb.sv
module rs485_uart_tx_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic       full;
    logic       baud_tick = 1'b0;
    logic       txd;
    logic       dir_tx;
    logic [3:0] divcnt = '0;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    always @(negedge clk) begin
        if (rst) begin
            divcnt    <= '0;
            baud_tick <= 1'b0;
        end else begin
            divcnt    <= divcnt + 1'b1;
            baud_tick <= (divcnt == 4'd15);
        end
    end

    rs485_uart_tx u_dut (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .full      (full),
        .baud_tick (baud_tick),
        .txd       (txd),
        .dir_tx    (dir_tx)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic tick_edge();
        do @(posedge clk); while (!baud_tick);
        @(negedge clk);
    endtask

    task automatic write_byte(input logic [7:0] d);
        wr_en   = 1'b1;
        wr_data = d;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic expect_frame(input logic [7:0] exp, input string req);
        tick_edge();
        chk(txd == 1'b0, {req, " start bit"}, txd, 0);
        chk(dir_tx == 1'b1, "R4 dir during start", dir_tx, 1);
        for (int i = 0; i < 8; i++) begin
            tick_edge();
            chk(txd == exp[i], "R2 data bit", txd, exp[i]);
            chk(dir_tx == 1'b1, "R4 dir during data", dir_tx, 1);
        end
        tick_edge();
        chk(txd == 1'b1, "R2 stop bit", txd, 1);
    endtask

    task automatic expect_guard();
        for (int g = 0; g < 3; g++) begin
            tick_edge();
            chk(dir_tx == 1'b1, "R5 dir held in guard", dir_tx, 1);
            chk(txd == 1'b1, "R5 line high in guard", txd, 1);
        end
        tick_edge();
        chk(dir_tx == 1'b0, "R5 dir released after guard", dir_tx, 0);
    endtask

    task automatic expect_lead();
        tick_edge();
        chk(dir_tx == 1'b1, "R3 dir raised for lead", dir_tx, 1);
        chk(txd == 1'b1, "R3 line idle during lead", txd, 1);
    endtask

    task automatic test_reset();
        chk(txd == 1'b1, "R1 txd in reset", txd, 1);
        chk(dir_tx == 1'b0, "R1 dir in reset", dir_tx, 0);
        chk(full == 1'b0, "R1 full in reset", full, 0);
        @(negedge clk);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        chk(txd == 1'b1 && dir_tx == 1'b0, "R1 idle after reset", {txd, dir_tx}, 2);
    endtask

    task automatic test_single();
        write_byte(8'hA5);
        expect_lead();
        expect_frame(8'hA5, "R2 R3 single");
        expect_guard();
    endtask

    task automatic test_back_to_back();
        write_byte(8'h96);
        write_byte(8'h01);
        expect_lead();
        expect_frame(8'h96, "R7 first");
        expect_frame(8'h01, "R7 no idle gap");
        expect_guard();
    endtask

    task automatic test_guard_cancel();
        write_byte(8'h3C);
        expect_lead();
        expect_frame(8'h3C, "R6 first");
        tick_edge();
        chk(dir_tx == 1'b1, "R6 guard running", dir_tx, 1);
        write_byte(8'h81);
        expect_frame(8'h81, "R6 cancel start");
        expect_guard();
    endtask

    task automatic test_full();
        tick_edge();
        for (int i = 0; i < 16; i++) write_byte(8'(8'h10 + i * 7));
        chk(full == 1'b1, "R8 full at 16", full, 1);
        write_byte(8'hEE);
        chk(full == 1'b1, "R8 still full", full, 1);
        chk(dir_tx == 1'b1 && txd == 1'b1, "R3 lead before burst", {dir_tx, txd}, 3);
        for (int i = 0; i < 16; i++) expect_frame(8'(8'h10 + i * 7), "R8 order");
        expect_guard();
        tick_edge();
        tick_edge();
        chk(dir_tx == 1'b0 && txd == 1'b1, "R8 dropped byte not sent", {dir_tx, txd}, 1);
        chk(full == 1'b0, "R8 full cleared", full, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        test_reset();
        test_single();
        test_back_to_back();
        test_guard_cancel();
        test_full();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule